// File: doc/BRIEF.md
# Thermal Alarm Output Controller

This block converts a stream of signed temperature samples into one alarm line for an open-drain pad. Samples are 9-bit two's complement values, one LSB per half degree Celsius, and arrive with a one-cycle valid strobe. Each sample is compared with a trip level and a release level supplied by the surrounding register file. The block then applies a consecutive-sample qualification filter. Finally it drives the alarm according to one of two behaviours.

In thermostat (comparator) mode the alarm follows the temperature with hysteresis. It turns on above the trip level and turns off below the release level. In event (interrupt) mode the alarm latches on each qualified event until the host performs any register read, which the bus logic reports as a one-cycle pulse. The events alternate between "rose above trip" and "fell below release".

A sleep input stops sample evaluation. In event mode, entering sleep also drops a pending alarm. A polarity bit decides whether an active alarm pulls the pad low or releases it. The register file resets the trip level to 0x0A0 (80 °C) and the release level to 0x096 (75 °C). The bench uses these values as its main thresholds.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After synchronous reset the alarm is inactive, so with `cfg_ctl[2]`=0 the pad enable `pad_pull_low` is 0.
- R2: In thermostat mode (`cfg_ctl[1]`=0), an inactive alarm turns on after a qualified sample strictly greater than `trip_level`. An active alarm turns off only after a qualified sample strictly less than `release_level`. Samples equal to either level change nothing.
- R3: All comparisons treat samples and levels as signed two's complement, so negative thresholds order correctly.
- R4: In event mode (`cfg_ctl[1]`=1), a qualified sample above `trip_level` latches the alarm on. Later samples, including ones below `release_level`, leave it on. The first `rd_pulse` clears it.
- R5: In event mode the awaited event starts as "above trip" and swaps to the other kind each time an event latches. After an above-trip event is cleared, a sample below `release_level` latches the alarm again, and a further read clears it.
- R6: `cfg_ctl[4:3]` sets how many consecutive qualifying samples an alarm change needs: 00→1, 01→2, 10→4, 11→6. A valid sample that does not qualify restarts the count from zero.
- R7: `cfg_ctl[2]`=0 makes the alarm active-low (`pad_pull_low`=1 while active). `cfg_ctl[2]`=1 inverts this (`pad_pull_low`=1 while inactive). The pad follows a change of this bit in the same cycle.
- R8: While `sleep` is 1, valid samples are not evaluated and do not advance the count. In thermostat mode the alarm holds its state through sleep.
- R9: In event mode, the clock edge that first sees `sleep` high clears the alarm.
- R10: A change of `cfg_ctl[1]` clears the alarm, re-arms for the above-trip event and zeroes the count. That edge evaluates no sample.
- R11: In thermostat mode `rd_pulse` has no effect on the alarm.
- R12: In event mode, samples are not counted while the alarm is latched. Counting toward the next event starts only after the read that clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_temp | input | 9 | Signed sample, 0.5 °C per LSB |
| trip_level | input | 9 | Signed trip (setpoint) level |
| release_level | input | 9 | Signed release (hysteresis) level |
| cfg_ctl | input | 4 | Bits 4:1: [4:3] filter depth code, [2] polarity, [1] mode |
| rd_pulse | input | 1 | One-cycle pulse on any host register read |
| sleep | input | 1 | Shutdown: halts sample evaluation |
| pad_pull_low | output | 1 | Open-drain pull-down enable |

## Verification
A sample, read pulse, sleep entry or mode change is acted on at the first rising edge where it is present. Its effect on `pad_pull_low` is therefore visible immediately after that single edge. A polarity change reaches the pad with no edge at all. The driver applies each stimulus half a cycle before the edge and queues one expected pad value per cycle. The monitor compares that value a short delay after the edge, so every result is checked in the cycle it is due. A multi-sample filter case queues the unchanged value for each sample before the one that completes the count.

// File: rtl/thermal_alarm_pkg.sv
`timescale 1ns/1ps
package thermal_alarm_pkg;

    localparam int TAP_TEMP_W = 9;
    localparam int TAP_NEED_W = 3;

    localparam logic [TAP_TEMP_W-1:0] TAP_DFLT_TRIP    = 9'h0A0;
    localparam logic [TAP_TEMP_W-1:0] TAP_DFLT_RELEASE = 9'h096;

    typedef enum logic {
        EVT_HOT  = 1'b0,
        EVT_COOL = 1'b1
    } evt_e;

    typedef struct packed {
        logic [1:0] qsel;
        logic       pol_high;
        logic       irq_mode;
    } ctl_t;

    function automatic ctl_t unpack_ctl(input logic [4:1] raw);
        ctl_t c;
        c.qsel     = raw[4:3];
        c.pol_high = raw[2];
        c.irq_mode = raw[1];
        return c;
    endfunction

    function automatic logic [TAP_NEED_W-1:0] qual_need(input logic [1:0] sel);
        logic [TAP_NEED_W-1:0] n;
        case (sel)
            2'b00:   n = TAP_NEED_W'(1);
            2'b01:   n = TAP_NEED_W'(2);
            2'b10:   n = TAP_NEED_W'(4);
            default: n = TAP_NEED_W'(6);
        endcase
        return n;
    endfunction

    function automatic evt_e evt_flip(input evt_e e);
        return (e == EVT_HOT) ? EVT_COOL : EVT_HOT;
    endfunction

endpackage

// File: rtl/tac_level_cmp.sv
`timescale 1ns/1ps
module tac_level_cmp
    import thermal_alarm_pkg::*;
#(
    parameter int TEMP_W = TAP_TEMP_W
) (
    input  logic signed [TEMP_W-1:0] temp,
    input  logic signed [TEMP_W-1:0] trip,
    input  logic signed [TEMP_W-1:0] rel,
    input  evt_e                     watch,
    output logic                     hit
);
    always_comb begin
        if (watch == EVT_HOT) hit = (temp > trip);
        else                  hit = (temp < rel);
    end
endmodule

// File: rtl/tac_fault_queue.sv
`timescale 1ns/1ps
module tac_fault_queue #(
    parameter int CNT_W = thermal_alarm_pkg::TAP_NEED_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             hit,
    input  logic [CNT_W-1:0] need,
    output logic             fire
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nx;

    always_comb begin
        run_nx = run_q + CNT_W'(1);
        fire   = step && hit && !clear && (run_nx >= need);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else if (step) begin
            if (!hit || fire) run_q <= '0;
            else              run_q <= run_nx;
        end
    end
endmodule

// File: rtl/tac_alarm_state.sv
`timescale 1ns/1ps
module tac_alarm_state
    import thermal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irq_mode,
    input  logic fire,
    input  logic rd_pulse,
    input  logic sleep,
    output logic alarm_q,
    output evt_e watch_q,
    output logic mode_flip,
    output logic sleep_entry,
    output logic hold_eval
);
    logic mode_q;
    logic sleep_q;

    always_comb begin
        mode_flip   = (irq_mode != mode_q);
        sleep_entry = sleep && !sleep_q;
        hold_eval   = irq_mode && alarm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= 1'b0;
            watch_q <= EVT_HOT;
            mode_q  <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            mode_q  <= irq_mode;
            sleep_q <= sleep;
            if (mode_flip) begin
                alarm_q <= 1'b0;
                watch_q <= EVT_HOT;
            end else if (irq_mode) begin
                if (sleep_entry) begin
                    alarm_q <= 1'b0;
                end else if (fire) begin
                    alarm_q <= 1'b1;
                    watch_q <= evt_flip(watch_q);
                end else if (rd_pulse) begin
                    alarm_q <= 1'b0;
                end
            end else if (fire) begin
                alarm_q <= !alarm_q;
                watch_q <= evt_flip(watch_q);
            end
        end
    end
endmodule

// File: rtl/tac_pad_drive.sv
`timescale 1ns/1ps
module tac_pad_drive (
    input  logic alarm,
    input  logic pol_high,
    output logic pull_low
);
    always_comb pull_low = alarm ^ pol_high;
endmodule

// File: rtl/thermal_alarm_ctrl.sv
`timescale 1ns/1ps
module thermal_alarm_ctrl
    import thermal_alarm_pkg::*;
#(
    parameter int TEMP_W = TAP_TEMP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [TEMP_W-1:0] smp_temp,
    input  logic signed [TEMP_W-1:0] trip_level,
    input  logic signed [TEMP_W-1:0] release_level,
    input  logic [4:1]               cfg_ctl,
    input  logic                     rd_pulse,
    input  logic                     sleep,
    output logic                     pad_pull_low
);
    localparam int CNT_W = TAP_NEED_W;

    ctl_t             ctl;
    logic [CNT_W-1:0] need;
    evt_e             watch_q;
    logic             hit;
    logic             step;
    logic             fire;
    logic             alarm_q;
    logic             mode_flip;
    logic             sleep_entry;
    logic             hold_eval;

    always_comb begin
        ctl  = unpack_ctl(cfg_ctl);
        need = qual_need(ctl.qsel);
        step = smp_valid && !sleep && !hold_eval;
    end

    tac_level_cmp #(.TEMP_W(TEMP_W)) u_cmp (
        .temp  (smp_temp),
        .trip  (trip_level),
        .rel   (release_level),
        .watch (watch_q),
        .hit   (hit)
    );

    tac_fault_queue #(.CNT_W(CNT_W)) u_fq (
        .clk   (clk),
        .rst   (rst),
        .clear (mode_flip),
        .step  (step),
        .hit   (hit),
        .need  (need),
        .fire  (fire)
    );

    tac_alarm_state u_state (
        .clk         (clk),
        .rst         (rst),
        .irq_mode    (ctl.irq_mode),
        .fire        (fire),
        .rd_pulse    (rd_pulse),
        .sleep       (sleep),
        .alarm_q     (alarm_q),
        .watch_q     (watch_q),
        .mode_flip   (mode_flip),
        .sleep_entry (sleep_entry),
        .hold_eval   (hold_eval)
    );

    tac_pad_drive u_pad (
        .alarm    (alarm_q),
        .pol_high (ctl.pol_high),
        .pull_low (pad_pull_low)
    );
endmodule

// File: rtl/tac_checker.sv
`timescale 1ns/1ps
module tac_checker #(
    parameter int TEMP_W = thermal_alarm_pkg::TAP_TEMP_W
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [TEMP_W-1:0] smp_temp,
    input logic [TEMP_W-1:0] trip_level,
    input logic [4:1]        cfg_ctl,
    input logic              rd_pulse,
    input logic              sleep,
    input logic              alarm_q,
    input logic              fire,
    input logic              mode_flip,
    input logic              sleep_entry
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $fell(rst) |-> !alarm_q);

    // R2
    cmp_rise_needs_hot_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ctl[1] && !mode_flip && !alarm_q &&
         !(smp_valid && !sleep && ($signed(smp_temp) > $signed(trip_level))))
        |=> !alarm_q);

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_ctl[1] && !mode_flip && alarm_q && !rd_pulse && !sleep_entry)
        |=> alarm_q);

    // R4
    irq_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_ctl[1] && !mode_flip && rd_pulse && !fire) |=> !alarm_q);

    // R8
    cmp_sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ctl[1] && !mode_flip && sleep) |=> $stable(alarm_q));

    // R9
    sleep_entry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_ctl[1] && sleep_entry) |=> !alarm_q);

    // R10
    mode_flip_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mode_flip |=> !alarm_q);
endmodule

bind thermal_alarm_ctrl tac_checker #(.TEMP_W(TEMP_W)) u_tac_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_valid   (smp_valid),
    .smp_temp    (smp_temp),
    .trip_level  (trip_level),
    .cfg_ctl     (cfg_ctl),
    .rd_pulse    (rd_pulse),
    .sleep       (sleep),
    .alarm_q     (alarm_q),
    .fire        (fire),
    .mode_flip   (mode_flip),
    .sleep_entry (sleep_entry)
);

// File: tb/test_thermal_alarm_ctrl.sv
`timescale 1ns/1ps
module test_thermal_alarm_ctrl;
    import thermal_alarm_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              smp_valid;
    logic signed [8:0] smp_temp;
    logic signed [8:0] trip_level;
    logic signed [8:0] release_level;
    logic [4:1]        cfg_ctl;
    logic              rd_pulse;
    logic              sleep;
    logic              pad_pull_low;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    thermal_alarm_ctrl i_thermal_alarm_ctrl (
        .clk           (clk),
        .rst           (rst),
        .smp_valid     (smp_valid),
        .smp_temp      (smp_temp),
        .trip_level    (trip_level),
        .release_level (release_level),
        .cfg_ctl       (cfg_ctl),
        .rd_pulse      (rd_pulse),
        .sleep         (sleep),
        .pad_pull_low  (pad_pull_low)
    );

    // Monitor: pops one expectation per edge, 2 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (pad_pull_low !== e) begin
                    n_fail++;
                    $display("FAIL %s: pad_pull_low=%0b expected %0b", t, pad_pull_low, e);
                end
            end
        end
    end

    // Driver: called at a falling edge, returns at the next one
    task automatic cyc(input bit v, input int t, input bit rd, input bit sd,
                       input bit e, input string tag);
        smp_valid = v;
        smp_temp  = 9'(t);
        rd_pulse  = rd;
        sleep     = sd;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic smp(input int t, input bit e, input string tag);
        cyc(1'b1, t, 1'b0, 1'b0, e, tag);
    endtask

    task automatic idle(input bit e, input string tag);
        cyc(1'b0, 0, 1'b0, 1'b0, e, tag);
    endtask

    task automatic rd(input bit e, input string tag);
        cyc(1'b0, 0, 1'b1, 1'b0, e, tag);
    endtask

    task automatic slp(input bit v, input int t, input bit e, input string tag);
        cyc(v, t, 1'b0, 1'b1, e, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run incomplete=1 expected 0");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; smp_temp = '0; rd_pulse = 1'b0; sleep = 1'b0;
        trip_level = TAP_DFLT_TRIP; release_level = TAP_DFLT_RELEASE;
        cfg_ctl = 4'b0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(0, "R1 reset idle");

        // Thermostat mode, filter depth 1
        smp(160, 0, "R2 equal to trip");
        smp(161, 1, "R2 above trip");
        smp(150, 1, "R2 equal to release");
        smp(155, 1, "R2 between levels");
        rd(1, "R11 read in thermostat");
        smp(149, 0, "R2 below release");

        // Signed thresholds
        trip_level = -9'sd10; release_level = -9'sd20;
        smp(-5, 1, "R3 -5 above -10");
        smp(-15, 1, "R3 -15 not below -20");
        smp(-21, 0, "R3 -21 below -20");
        trip_level = TAP_DFLT_TRIP; release_level = TAP_DFLT_RELEASE;
        idle(0, "R3 restore");

        // Filter depth 2
        cfg_ctl = 4'b0100;
        smp(170, 0, "R6 depth2 first");
        smp(170, 1, "R6 depth2 second");
        smp(100, 1, "R6 depth2 cool 1");
        smp(165, 1, "R6 non-qualifying restart");
        smp(100, 1, "R6 cool after restart");
        smp(100, 0, "R6 depth2 cool 2");

        // Filter depth 4
        cfg_ctl = 4'b1000;
        for (int i = 0; i < 3; i++) smp(170, 0, "R6 depth4 partial");
        smp(100, 0, "R6 depth4 restart");
        for (int i = 0; i < 3; i++) smp(170, 0, "R6 depth4 count");
        smp(170, 1, "R6 depth4 fourth");
        for (int i = 0; i < 3; i++) smp(100, 1, "R6 depth4 cool partial");
        smp(100, 0, "R6 depth4 cool fourth");

        // Filter depth 6
        cfg_ctl = 4'b1100;
        for (int i = 0; i < 5; i++) smp(170, 0, "R6 depth6 partial");
        smp(170, 1, "R6 depth6 sixth");
        cfg_ctl = 4'b0000;
        smp(100, 0, "R6 depth1 cool");

        // Polarity
        cfg_ctl = 4'b0010;
        idle(1, "R7 high polarity idle");
        smp(170, 0, "R7 high polarity active");
        cfg_ctl = 4'b0000;
        idle(1, "R7 low polarity active");
        smp(100, 0, "R7 low polarity idle");

        // Sleep in thermostat mode
        smp(170, 1, "R8 set before sleep");
        slp(1, 100, 1, "R8 sleep holds active");
        slp(1, 100, 1, "R8 sleep holds active 2");
        idle(1, "R8 wake");
        smp(100, 0, "R8 after wake");
        slp(1, 170, 0, "R8 sleep ignores hot");
        idle(0, "R8 wake 2");

        // Event mode
        cfg_ctl = 4'b0001;
        idle(0, "R10 switch to event");
        smp(170, 1, "R4 over-trip latch");
        smp(100, 1, "R4 stays through cool");
        rd(0, "R4 read clears");
        smp(170, 0, "R5 hot not awaited");
        smp(100, 1, "R5 under-release latch");
        rd(0, "R5 read clears under");
        smp(100, 0, "R5 cool not awaited");
        smp(170, 1, "R5 over again");
        rd(0, "R5 read clears over");

        // No counting while latched, depth 2
        cfg_ctl = 4'b0101;
        smp(100, 0, "R12 depth2 cool 1");
        smp(100, 1, "R12 depth2 cool 2");
        smp(170, 1, "R12 latched hot");
        rd(0, "R12 read");
        smp(170, 0, "R12 count restarted");
        smp(170, 1, "R12 second after read");

        // Sleep entry in event mode
        slp(0, 0, 0, "R9 sleep entry clears");
        slp(1, 100, 0, "R8 event sleep ignores 1");
        slp(1, 100, 0, "R8 event sleep ignores 2");
        idle(0, "R9 wake");

        // Mode change back to thermostat re-arms for hot
        cfg_ctl = 4'b0100;
        idle(0, "R10 switch to thermostat");
        smp(100, 0, "R10 cool ignored 1");
        smp(100, 0, "R10 cool ignored 2");
        smp(170, 0, "R10 hot 1");
        smp(170, 1, "R10 hot 2");
        cfg_ctl = 4'b0101;
        idle(0, "R10 switch clears active");

        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule